// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Engine (Standard and Overdrive Speed)

This block is the bit-level end of a slave on a single open-drain data wire shared with one bus master. It watches the synchronized wire level, recognises the long low that the master uses as a bus reset, and answers with a presence pulse after a short gap. It also decodes the short time slots that carry data. In a write slot it samples the wire at a fixed point after the falling edge. In a read slot it holds the wire low through that point when the bit to send is zero. Bits are gathered least-significant first, and each completed byte goes to the command layer above with a one-cycle strobe.

All timing counts pulses of a free-running microsecond tick. A mode input picks between two threshold sets at runtime. The standard set uses a 480-tick reset threshold, a 30-tick presence gap, a 120-tick presence pulse and a 30-tick sample point. The overdrive set uses 48, 3, 12 and 3 ticks. The slave never drives the wire high. It only asserts a pull-down enable for an external open-drain driver.

The command layer decides what kind of slot comes next. It raises `send_en` before read slots and supplies the byte to transmit on `tx_byte`.

Top module: `owb_slave`

## Requirements
- R1: After reset, `pull_low`, `rx_valid` and `reset_seen` are all 0.
- R2: A low lasting at least the reset threshold (480 ticks in standard speed) produces a single-cycle `reset_seen` pulse on the first cycle the wire is high again. A shorter low, such as 300 ticks, produces none.
- R3: In standard speed the presence pull-down starts 30 ticks after the reset ends and lasts 120 ticks. The master therefore sees it start within 15 to 60 ticks and last 60 to 240 ticks.
- R4: With `fast_mode`=1 the reset threshold is 48 ticks, the presence gap is 3 ticks and the presence length is 12 ticks. A 100-tick low is a reset in overdrive but not in standard speed.
- R5: A written bit is the wire level sampled at the 30th tick (standard) or the 3rd tick (overdrive) after the falling edge. Low is 0 and high is 1.
- R6: Bits fill `rx_byte` least-significant first. After the 8th bit `rx_byte` is updated and `rx_valid` is high for exactly one cycle.
- R7: If `send_en`=1 at a falling edge, the slave pulls low from then until the sample point when bit k of `tx_byte` is 0, where k counts the bits already taken in the current byte. It leaves the wire alone when that bit is 1. The sampled wire also goes into `rx_byte`.
- R8: A low that reaches the reset threshold discards any partial byte, so the next eight slots form a fresh byte.
- R9: With `send_en`=0, the slave never asserts `pull_low` during data slots. It pulls low only for presence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse per microsecond |
| fast_mode | input | 1 | 1 selects overdrive thresholds |
| line_in | input | 1 | Synchronized wire level |
| send_en | input | 1 | Next slots are read slots |
| tx_byte | input | 8 | Byte to transmit, LSB first |
| pull_low | output | 1 | Enable for the open-drain pull-down |
| rx_byte | output | 8 | Last byte assembled from the wire |
| rx_valid | output | 1 | One-cycle strobe when rx_byte is updated |
| reset_seen | output | 1 | One-cycle pulse when a bus reset ends |

## Verification
`reset_seen` rises one clock after the first high sample that follows a qualifying low. A written bit is taken on the clock after its sampling tick, and `rx_valid` appears on that same clock for the 8th bit. A read-slot pull-down appears one clock after the falling edge and ends one clock after the sampling tick. Because of this one-clock lag, the bench counts whole ticks as the master sees them and places its own read and write actions a few ticks away from each slave threshold. It checks presence timing against tick ranges rather than exact cycles, and it reads strobes and bytes through a monitor that samples on the falling clock edge.

// File: rtl/owb_pkg.sv
// Package: shared state encoding and timing-set bundle for the single-wire
// slave. Assumes all thresholds fit in 16-bit tick counts.
package owb_pkg;

    localparam int TW = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT,
        ST_RECOV,
        ST_PD_WAIT,
        ST_PD_DRIVE
    } owb_state_t;

    typedef struct packed {
        logic [TW-1:0] rst_min;
        logic [TW-1:0] smp_at;
        logic [TW-1:0] pd_wait;
        logic [TW-1:0] pd_len;
    } owb_times_t;

endpackage

// File: rtl/owb_speed_sel.sv
// Module: selects the active threshold set from the speed input.
// Assumes fast_mode changes only while the bus is idle.
module owb_speed_sel
    import owb_pkg::*;
#(
    parameter int RST_STD  = 480,
    parameter int SMP_STD  = 30,
    parameter int PDW_STD  = 30,
    parameter int PDL_STD  = 120,
    parameter int RST_FAST = 48,
    parameter int SMP_FAST = 3,
    parameter int PDW_FAST = 3,
    parameter int PDL_FAST = 12
) (
    input  logic       fast_mode,
    output owb_times_t times
);

    localparam owb_times_t STD_SET = '{
        rst_min: TW'(RST_STD),  smp_at: TW'(SMP_STD),
        pd_wait: TW'(PDW_STD),  pd_len: TW'(PDL_STD)};
    localparam owb_times_t FAST_SET = '{
        rst_min: TW'(RST_FAST), smp_at: TW'(SMP_FAST),
        pd_wait: TW'(PDW_FAST), pd_len: TW'(PDL_FAST)};

    // Pick the threshold set for the current speed.
    always_comb begin
        times = fast_mode ? FAST_SET : STD_SET;
    end

endmodule

// File: rtl/owb_lowtimer.sv
// Module: measures how long the wire has been low, in ticks, and flags a
// low that has reached the reset threshold. The flag stays set until the
// first cycle the wire is high again, then clears.
module owb_lowtimer
    import owb_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line_in,
    input  logic [TW-1:0] rst_min,
    output logic          long_low
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] low_cnt;

    // Count ticks while the wire is low, saturating; clear when high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (line_in)
            low_cnt <= '0;
        else if (tick && low_cnt != CNT_MAX)
            low_cnt <= low_cnt + 1'b1;
    end

    // Flag a reset-length low; hold it through the first high cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            long_low <= 1'b0;
        else if (line_in)
            long_low <= 1'b0;
        else if (TW'(low_cnt) >= rst_min)
            long_low <= 1'b1;
    end

    AST_LONGLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (long_low && !line_in) |=> long_low); // R8

endmodule

// File: rtl/owb_shifter.sv
// Module: assembles sampled bits LSB-first into a byte and strobes when the
// last bit arrives. An abort input drops any partial byte. Assumes at most
// one sample per cycle.
module owb_shifter #(
    parameter int BW = 8,
    localparam int IW = $clog2(BW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_en,
    input  logic          smp_bit,
    input  logic          abort,
    output logic [IW-1:0] bit_idx,
    output logic [BW-1:0] rx_byte,
    output logic          rx_valid
);

    localparam logic [IW-1:0] LAST = IW'(BW - 1);

    logic [BW-1:0] sreg;
    logic [BW-1:0] shifted;

    // Next shift-register value with the new bit entering at the top.
    always_comb begin
        shifted = {smp_bit, sreg[BW-1:1]};
    end

    // Shift bits in, count them, and publish the byte on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg     <= '0;
            bit_idx  <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (abort) begin
                bit_idx <= '0;
                sreg    <= '0;
            end else if (smp_en) begin
                sreg <= shifted;
                if (bit_idx == LAST) begin
                    bit_idx  <= '0;
                    rx_byte  <= shifted;
                    rx_valid <= 1'b1;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

    AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6
    AST_STROBE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(smp_en)); // R5
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (bit_idx == '0)); // R8

endmodule

// File: rtl/owb_slot_fsm.sv
// Module: sequences data slots and the reset/presence exchange. It detects
// falling edges, times the sample point, drives read-slot zeros and the
// presence pulse, and reports the end of a bus reset. It assumes line_in is
// already synchronized and that tick is a one-cycle pulse.
module owb_slot_fsm
    import owb_pkg::*;
#(
    parameter int PW = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line_in,
    input  logic       long_low,
    input  owb_times_t times,
    input  logic       send_en,
    input  logic       tx_bit,
    output logic       pull_low,
    output logic       smp_en,
    output logic       smp_bit,
    output logic       reset_seen
);

    owb_state_t    st;
    logic [PW-1:0] ph_cnt;
    logic          line_q;
    logic          send_q;
    logic          drive_q;
    logic          fall;
    logic          in_pd;
    logic          ph_hit_smp;
    logic          ph_hit_wait;
    logic          ph_hit_len;

    // Decode edges and phase-counter matches against the active thresholds.
    always_comb begin
        fall        = line_q && !line_in;
        in_pd       = (st == ST_PD_WAIT) || (st == ST_PD_DRIVE);
        ph_hit_smp  = tick && (TW'(ph_cnt) == times.smp_at  - 1'b1);
        ph_hit_wait = tick && (TW'(ph_cnt) == times.pd_wait - 1'b1);
        ph_hit_len  = tick && (TW'(ph_cnt) == times.pd_len  - 1'b1);
    end

    // Open-drain enable: presence pulse or a zero in a read slot.
    always_comb begin
        pull_low = (st == ST_PD_DRIVE) || ((st == ST_SLOT) && drive_q);
    end

    // Main sequencer: slot timing, presence timing and reset detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            ph_cnt     <= '0;
            line_q     <= 1'b1;
            send_q     <= 1'b0;
            drive_q    <= 1'b0;
            smp_en     <= 1'b0;
            smp_bit    <= 1'b0;
            reset_seen <= 1'b0;
        end else begin
            line_q     <= line_in;
            smp_en     <= 1'b0;
            reset_seen <= 1'b0;
            if (tick)
                ph_cnt <= ph_cnt + 1'b1;
            case (st)
                ST_IDLE: begin
                    if (fall) begin
                        st      <= ST_SLOT;
                        ph_cnt  <= '0;
                        send_q  <= send_en;
                        drive_q <= send_en && !tx_bit;
                    end
                end
                ST_SLOT: begin
                    if (ph_hit_smp) begin
                        smp_en  <= 1'b1;
                        smp_bit <= line_in;
                        drive_q <= 1'b0;
                        st      <= ST_RECOV;
                    end
                end
                ST_RECOV: begin
                    if (line_in)
                        st <= ST_IDLE;
                end
                ST_PD_WAIT: begin
                    if (ph_hit_wait) begin
                        st     <= ST_PD_DRIVE;
                        ph_cnt <= '0;
                    end
                end
                ST_PD_DRIVE: begin
                    if (ph_hit_len)
                        st <= ST_RECOV;
                end
                default: st <= ST_IDLE;
            endcase
            if (!in_pd && long_low && line_in) begin
                reset_seen <= 1'b1;
                drive_q    <= 1'b0;
                st         <= ST_PD_WAIT;
                ph_cnt     <= '0;
            end
        end
    end

    AST_RSTPULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen |=> !reset_seen); // R2
    AST_RSTPULSE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen |-> $past(long_low)); // R2
    AST_PD_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
        reset_seen |=> !pull_low); // R3
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_SLOT) && !send_q) |-> !pull_low); // R9

endmodule

// File: rtl/owb_slave.sv
// Module: top of the single-wire bit engine. It ties together the speed
// selector, the low-duration timer, the slot sequencer and the byte
// shifter. It assumes line_in is synchronized and tick pulses once per
// microsecond.
module owb_slave #(
    parameter int BW       = 8,
    parameter int RST_STD  = 480,
    parameter int SMP_STD  = 30,
    parameter int PDW_STD  = 30,
    parameter int PDL_STD  = 120,
    parameter int RST_FAST = 48,
    parameter int SMP_FAST = 3,
    parameter int PDW_FAST = 3,
    parameter int PDL_FAST = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          fast_mode,
    input  logic          line_in,
    input  logic          send_en,
    input  logic [BW-1:0] tx_byte,
    output logic          pull_low,
    output logic [BW-1:0] rx_byte,
    output logic          rx_valid,
    output logic          reset_seen
);
    import owb_pkg::*;

    localparam int IW    = $clog2(BW);
    localparam int CW    = $clog2(RST_STD + 2);
    localparam int PMAX1 = (SMP_STD > PDW_STD) ? SMP_STD : PDW_STD;
    localparam int PMAX  = (PDL_STD > PMAX1) ? PDL_STD : PMAX1;
    localparam int PW    = $clog2(PMAX + 2);

    owb_times_t    times;
    logic          long_low;
    logic          smp_en;
    logic          smp_bit;
    logic [IW-1:0] bit_idx;
    logic          tx_bit;

    // Bit of the transmit byte for the coming slot.
    always_comb begin
        tx_bit = tx_byte[bit_idx];
    end

    owb_speed_sel #(
        .RST_STD(RST_STD), .SMP_STD(SMP_STD), .PDW_STD(PDW_STD), .PDL_STD(PDL_STD),
        .RST_FAST(RST_FAST), .SMP_FAST(SMP_FAST), .PDW_FAST(PDW_FAST), .PDL_FAST(PDL_FAST)
    ) u_speed (
        .fast_mode (fast_mode),
        .times     (times)
    );

    owb_lowtimer #(.CW(CW)) u_low (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .line_in  (line_in),
        .rst_min  (times.rst_min),
        .long_low (long_low)
    );

    owb_slot_fsm #(.PW(PW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .line_in    (line_in),
        .long_low   (long_low),
        .times      (times),
        .send_en    (send_en),
        .tx_bit     (tx_bit),
        .pull_low   (pull_low),
        .smp_en     (smp_en),
        .smp_bit    (smp_bit),
        .reset_seen (reset_seen)
    );

    owb_shifter #(.BW(BW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .smp_bit  (smp_bit),
        .abort    (long_low),
        .bit_idx  (bit_idx),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

endmodule

// File: tb/sim_owb_slave.sv
`timescale 1ns/1ps
module sim_owb_slave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       fast_mode = 1'b0;
    logic       send_en = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       master_low = 1'b0;
    logic       line_in;
    logic       pull_low;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       reset_seen;

    int n_tests = 0;
    int n_fail  = 0;
    int rx_cnt  = 0;
    int rs_cnt  = 0;
    int pull_cyc = 0;
    logic [7:0] last_rx = 8'h00;
    logic [2:0] tdiv = '0;
    bit done = 1'b0;

    assign line_in = !(master_low || pull_low);

    always #5 clk = !clk;

    // Microsecond tick: one pulse every 5 clocks.
    always @(posedge clk) begin
        if (tdiv == 3'd4) begin
            tdiv <= '0;
            tick <= 1'b1;
        end else begin
            tdiv <= tdiv + 1'b1;
            tick <= 1'b0;
        end
    end

    owb_slave u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fast_mode(fast_mode),
        .line_in(line_in), .send_en(send_en), .tx_byte(tx_byte),
        .pull_low(pull_low), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .reset_seen(reset_seen)
    );

    // Monitor of strobes, reset pulses and pull-down cycles.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                rx_cnt  <= rx_cnt + 1;
                last_rx <= rx_byte;
            end
            if (reset_seen) rs_cnt <= rs_cnt + 1;
            if (pull_low) pull_cyc <= pull_cyc + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_tests++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!tick) @(negedge clk);
        end
    endtask

    // Hold the wire low for len ticks, release, then time the presence pulse.
    task automatic bus_low(input int len, output int pd_dly, output int pd_len);
        master_low = 1'b1;
        wait_ticks(len);
        master_low = 1'b0;
        pd_dly = 0;
        pd_len = 0;
        while (!pull_low && pd_dly < 400) begin
            wait_ticks(1);
            pd_dly++;
        end
        while (pull_low && pd_len < 400) begin
            wait_ticks(1);
            pd_len++;
        end
        wait_ticks(3);
    endtask

    task automatic write_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            master_low = 1'b1;
            if (fast_mode) begin
                wait_ticks(b[i] ? 1 : 8);
                master_low = 1'b0;
                wait_ticks(b[i] ? 9 : 2);
            end else begin
                wait_ticks(b[i] ? 5 : 60);
                master_low = 1'b0;
                wait_ticks(b[i] ? 65 : 10);
            end
            wait_ticks(2);
        end
    endtask

    task automatic read_byte(output logic [7:0] got);
        for (int i = 0; i < 8; i++) begin
            master_low = 1'b1;
            wait_ticks(1);
            master_low = 1'b0;
            wait_ticks(fast_mode ? 1 : 9);
            got[i] = line_in;
            wait_ticks(fast_mode ? 8 : 60);
            wait_ticks(2);
        end
    endtask

    // Vector table: {fast, read-slot, data}
    localparam logic [9:0] VEC [10] = '{
        {1'b0, 1'b0, 8'hA5}, {1'b0, 1'b0, 8'h00}, {1'b0, 1'b1, 8'h3C},
        {1'b1, 1'b0, 8'hFF}, {1'b1, 1'b0, 8'h81}, {1'b1, 1'b1, 8'h5A},
        {1'b1, 1'b1, 8'h00}, {1'b0, 1'b1, 8'hFF}, {1'b0, 1'b0, 8'h96},
        {1'b1, 1'b0, 8'h01}
    };

    initial begin
        #(1_400_000 * 10);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int dly, len, rs0, rx0, pc0;
        logic [7:0] got;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pull_low", int'(pull_low), 0);
        chk("R1 rx_valid", int'(rx_valid), 0);
        chk("R1 reset_seen", int'(reset_seen), 0);

        // R2/R3 standard reset and presence
        rs0 = rs_cnt;
        bus_low(500, dly, len);
        chk("R2 std reset pulse count", rs_cnt - rs0, 1);
        chk_rng("R3 std presence delay", dly, 15, 60);
        chk_rng("R3 std presence length", len, 60, 240);

        // R2 short low is no reset
        rs0 = rs_cnt;
        bus_low(300, dly, len);
        chk("R2 short low no reset", rs_cnt - rs0, 0);

        // R4 100-tick low: not a reset in standard, a reset in overdrive
        rs0 = rs_cnt;
        bus_low(100, dly, len);
        chk("R4 100-tick low in standard", rs_cnt - rs0, 0);
        fast_mode = 1'b1;
        wait_ticks(3);
        rs0 = rs_cnt;
        bus_low(100, dly, len);
        chk("R4 overdrive reset pulse count", rs_cnt - rs0, 1);
        chk_rng("R4 overdrive presence delay", dly, 2, 6);
        chk_rng("R4 overdrive presence length", len, 8, 24);

        // Vector table
        for (int v = 0; v < 10; v++) begin
            fast_mode = VEC[v][9];
            wait_ticks(3);
            rx0 = rx_cnt;
            pc0 = pull_cyc;
            if (VEC[v][8]) begin
                tx_byte = VEC[v][7:0];
                send_en = 1'b1;
                read_byte(got);
                send_en = 1'b0;
                chk("R7 master-read byte", int'(got), int'(VEC[v][7:0]));
                chk("R7 rx_byte records wire", int'(last_rx), int'(VEC[v][7:0]));
            end else begin
                tx_byte = 8'h00;
                write_bits(VEC[v][7:0], 8);
                chk("R5 R6 written byte", int'(last_rx), int'(VEC[v][7:0]));
                chk("R9 no pull in write slots", pull_cyc - pc0, 0);
            end
            chk("R6 one strobe per byte", rx_cnt - rx0, 1);
        end

        // R8 partial byte discarded by reset
        fast_mode = 1'b0;
        wait_ticks(3);
        write_bits(8'h07, 3);
        bus_low(500, dly, len);
        rx0 = rx_cnt;
        write_bits(8'h6B, 8);
        chk("R8 byte after abort", int'(last_rx), 8'h6B);
        chk("R8 strobe count after abort", rx_cnt - rx0, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule